// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit forms a 32-bit linear address from a segment value and an offset. It has two modes, chosen by a mode input. In legacy mode the segment value is scaled by sixteen and added to the offset, and no protection check runs. In protected mode the segment value is a selector. Its index field picks an entry in a small internal descriptor table. That entry supplies a base, a limit and a privilege level. The unit adds the base to the offset and reports a fault when the offset reaches the limit, when the caller is not privileged enough, or when the index lies outside the loaded part of the table.

The caller's privilege comes from the two low bits of the code-segment selector, which is a separate input. Level 0 is the most privileged and level 3 is the user level. Software fills the table through a write port and sets how many entries are valid through a separate count write. Both writes take effect only at level 0. Every request receives its response exactly one cycle later.

Top module: `seg_xlate`

## Requirements
- R1: With `prot_en` low, the response address is `req_sel*16 + req_off` modulo 2^32, and the response never faults, whatever the privilege or table state.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: With `prot_en` high and no fault, the response address is the base of entry `req_sel[6:3]` plus `req_off`, modulo 2^32.
- R4: In protected mode an offset greater than or equal to the entry's limit faults with cause 2'b01. An offset one below the limit does not fault.
- R5: The current level is `cs_sel[1:0]`. In protected mode, a current level numerically greater than the entry's level faults with cause 2'b10. Equal or lower levels pass.
- R6: In protected mode, an index field `req_sel[15:3]` that is greater than or equal to the valid-entry count faults with cause 2'b11. Priority is index over privilege over limit.
- R7: A faulting response drives `rsp_fault` high, a nonzero cause and a zero address. A clean response drives `rsp_fault` low and cause 2'b00.
- R8: Descriptor writes and count writes take effect only when `cs_sel[1:0]` is 0. At any other level they leave the table unchanged, and `wr_reject` is high in the next cycle. A count above the table depth is stored as the depth.
- R9: After reset `rsp_valid` and `rsp_fault` are low, the valid-entry count is zero, and every entry has base 0, limit 0 and level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_en | input | 1 | 1 = protected mode, 0 = legacy mode |
| cs_sel | input | 16 | Code-segment selector; bits [1:0] give the current level |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 16 | Segment value or selector |
| req_off | input | 32 | Offset |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_lin | output | 32 | Linear address (zero on fault) |
| rsp_fault | output | 1 | Fault flag |
| rsp_cause | output | 2 | 01 limit, 10 privilege, 11 index, 00 none |
| dw_en | input | 1 | Descriptor write strobe |
| dw_idx | input | 4 | Entry to write |
| dw_base | input | 32 | Base to write |
| dw_limit | input | 32 | Limit to write |
| dw_dpl | input | 2 | Privilege level to write |
| tl_en | input | 1 | Valid-entry count write strobe |
| tl_val | input | 5 | Valid-entry count |
| wr_reject | output | 1 | A write was refused in the previous cycle |

## Verification
The hardest cases to reach are those where two fault conditions hold together, so that only the priority order decides the cause. Another hard case is a refused write, whose only lasting sign is that later translations still see the old table. The stimulus first fills entries with chosen limits and levels. It then issues selectors whose index, level and offset break two rules at once. After each refused write it translates through the entry that the write targeted and checks the old base, and it checks that an index beyond the count still faults. A selector whose low index bits hit a valid entry but whose upper index bits are nonzero checks that the whole index field is compared.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter int NDESC = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         prot_en,
  input  logic [SW-1:0]                cs_sel,
  input  logic                         req_valid,
  input  logic [SW-1:0]                req_sel,
  input  logic [AW-1:0]                req_off,
  output logic                         rsp_valid,
  output logic [AW-1:0]                rsp_lin,
  output logic                         rsp_fault,
  output logic [1:0]                   rsp_cause,
  input  logic                         dw_en,
  input  logic [$clog2(NDESC)-1:0]     dw_idx,
  input  logic [AW-1:0]                dw_base,
  input  logic [AW-1:0]                dw_limit,
  input  logic [1:0]                   dw_dpl,
  input  logic                         tl_en,
  input  logic [$clog2(NDESC+1)-1:0]   tl_val,
  output logic                         wr_reject
);
  localparam int IW = $clog2(NDESC);
  localparam int CW = $clog2(NDESC+1);
  localparam int XW = SW - 3;

  localparam logic [1:0] C_NONE = 2'b00;
  localparam logic [1:0] C_LIM  = 2'b01;
  localparam logic [1:0] C_PRIV = 2'b10;
  localparam logic [1:0] C_IDX  = 2'b11;

  logic [AW-1:0] base_q  [NDESC];
  logic [AW-1:0] limit_q [NDESC];
  logic [1:0]    dpl_q   [NDESC];
  logic [CW-1:0] cnt_q;

  wire [1:0]    cpl   = cs_sel[1:0];
  wire          wr_ok = (cpl == 2'd0);
  wire [XW-1:0] idx   = req_sel[SW-1:3];
  wire [IW-1:0] slot  = idx[IW-1:0];

  wire idx_bad  = idx >= XW'(cnt_q);
  wire priv_bad = cpl > dpl_q[slot];
  wire lim_bad  = req_off >= limit_q[slot];

  wire [AW-1:0] real_lin = AW'({req_sel, 4'b0000}) + req_off;
  wire [AW-1:0] prot_lin = base_q[slot] + req_off;

  logic [1:0] cause_d;
  always_comb begin
    if (!prot_en)      cause_d = C_NONE;
    else if (idx_bad)  cause_d = C_IDX;
    else if (priv_bad) cause_d = C_PRIV;
    else if (lim_bad)  cause_d = C_LIM;
    else               cause_d = C_NONE;
  end

  wire [CW-1:0] cnt_d = (tl_val > CW'(NDESC)) ? CW'(NDESC) : tl_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        dpl_q[i]   <= '0;
      end
      cnt_q     <= '0;
      wr_reject <= 1'b0;
    end else begin
      if (dw_en && wr_ok) begin
        base_q[dw_idx]  <= dw_base;
        limit_q[dw_idx] <= dw_limit;
        dpl_q[dw_idx]   <= dw_dpl;
      end
      if (tl_en && wr_ok) cnt_q <= cnt_d;
      wr_reject <= (dw_en || tl_en) && !wr_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_lin   <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= C_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= (cause_d != C_NONE);
        rsp_cause <= cause_d;
        if (cause_d != C_NONE) rsp_lin <= '0;
        else                   rsp_lin <= prot_en ? prot_lin : real_lin;
      end
    end
  end

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_legacy_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !prot_en) |=> (!rsp_fault && rsp_cause == C_NONE));
  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_lin == '0 && rsp_cause != C_NONE));
  p_clean_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> rsp_cause == C_NONE);
  p_reject_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dw_en || tl_en) && cs_sel[1:0] != 2'd0) |=> wr_reject);
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel[1:0] != 2'd0) |=> $stable(cnt_q));
  p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NDESC));
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_en = 1'b0;
  logic [15:0] cs_sel = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_sel = '0;
  logic [31:0] req_off = '0;
  logic        rsp_valid;
  logic [31:0] rsp_lin;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        dw_en = 1'b0;
  logic [3:0]  dw_idx = '0;
  logic [31:0] dw_base = '0;
  logic [31:0] dw_limit = '0;
  logic [1:0]  dw_dpl = '0;
  logic        tl_en = 1'b0;
  logic [4:0]  tl_val = '0;
  logic        wr_reject;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .cs_sel(cs_sel),
    .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_lin(rsp_lin), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .dw_en(dw_en), .dw_idx(dw_idx),
    .dw_base(dw_base), .dw_limit(dw_limit), .dw_dpl(dw_dpl),
    .tl_en(tl_en), .tl_val(tl_val), .wr_reject(wr_reject)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic pmode, input logic [1:0] lvl,
                       input logic [15:0] sel, input logic [31:0] off,
                       input logic [31:0] exp_lin, input logic [1:0] exp_cause,
                       input string tag);
    @(negedge clk);
    prot_en = pmode; cs_sel = {14'd0, lvl};
    req_valid = 1'b1; req_sel = sel; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
    check({tag, " lin"},   rsp_lin, exp_lin);
    check({tag, " cause"}, {30'd0, rsp_cause}, {30'd0, exp_cause});
    check({tag, " fault"}, {31'd0, rsp_fault}, {31'd0, exp_cause != 2'b00});
  endtask

  task automatic put_desc(input logic [1:0] lvl, input logic [3:0] i,
                          input logic [31:0] b, input logic [31:0] l,
                          input logic [1:0] d, output logic rej);
    @(negedge clk);
    cs_sel = {14'd0, lvl}; dw_en = 1'b1; dw_idx = i;
    dw_base = b; dw_limit = l; dw_dpl = d;
    @(negedge clk);
    dw_en = 1'b0;
    rej = wr_reject;
  endtask

  task automatic put_count(input logic [1:0] lvl, input logic [4:0] n,
                           output logic rej);
    @(negedge clk);
    cs_sel = {14'd0, lvl}; tl_en = 1'b1; tl_val = n;
    @(negedge clk);
    tl_en = 1'b0;
    rej = wr_reject;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R9 rsp_fault after reset", {31'd0, rsp_fault}, 32'd0);
    rst_n = 1'b1;
    xlate(1'b1, 2'd0, 16'h0000, 32'h0, 32'h0, 2'b11, "R9 zero count faults index");
  endtask

  task automatic t_legacy;
    xlate(1'b0, 2'd3, 16'h1234, 32'h0000_5678, 32'h0001_79B8, 2'b00, "R1 legacy sum");
    xlate(1'b0, 2'd3, 16'hFFFF, 32'hFFFF_FFFF, 32'h000F_FFEF, 2'b00, "R1 legacy wrap");
    @(negedge clk);
    check("R2 idle gives no response", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_load;
    logic r;
    put_desc(2'd0, 4'd1, 32'h0010_0000, 32'h0000_1000, 2'd3, r);
    check("R8 level0 write accepted", {31'd0, r}, 32'd0);
    put_desc(2'd0, 4'd2, 32'hFFFF_F000, 32'hFFFF_FFFF, 2'd0, r);
    put_desc(2'd0, 4'd5, 32'h0000_2000, 32'h0000_0010, 2'd1, r);
    put_count(2'd0, 5'd6, r);
    check("R8 level0 count accepted", {31'd0, r}, 32'd0);
  endtask

  task automatic t_protected;
    xlate(1'b1, 2'd3, 16'h000B, 32'h0000_0FFF, 32'h0010_0FFF, 2'b00, "R3 base plus offset");
    xlate(1'b1, 2'd3, 16'h000B, 32'h0000_1000, 32'h0, 2'b01, "R4 offset at limit");
    xlate(1'b1, 2'd0, 16'h0010, 32'h0000_2000, 32'h0000_1000, 2'b00, "R3 wrap");
    xlate(1'b1, 2'd1, 16'h0010, 32'h0000_2000, 32'h0, 2'b10, "R5 level above dpl");
    xlate(1'b1, 2'd1, 16'h0028, 32'h0000_000F, 32'h0000_200F, 2'b00, "R5 equal level ok");
    xlate(1'b1, 2'd0, 16'h0028, 32'h0000_000F, 32'h0000_200F, 2'b00, "R5 lower level ok");
    xlate(1'b1, 2'd2, 16'h0028, 32'h0000_0010, 32'h0, 2'b10, "R6 priv over limit");
  endtask

  task automatic t_index;
    xlate(1'b1, 2'd0, 16'h0030, 32'h0, 32'h0, 2'b11, "R6 index equals count");
    xlate(1'b1, 2'd0, 16'h8008, 32'h0, 32'h0, 2'b11, "R6 upper index bits");
    xlate(1'b1, 2'd3, 16'h0033, 32'hFFFF_FFFF, 32'h0, 2'b11, "R6 index over priv and limit");
  endtask

  task automatic t_reject;
    logic r;
    put_desc(2'd3, 4'd1, 32'h0, 32'hFFFF_FFFF, 2'd3, r);
    check("R8 level3 desc write flagged", {31'd0, r}, 32'd1);
    xlate(1'b1, 2'd3, 16'h000B, 32'h0000_0004, 32'h0010_0004, 2'b00, "R8 entry unchanged");
    put_count(2'd1, 5'd16, r);
    check("R8 level1 count write flagged", {31'd0, r}, 32'd1);
    xlate(1'b1, 2'd0, 16'h0030, 32'h0, 32'h0, 2'b11, "R8 count unchanged");
    put_count(2'd0, 5'd31, r);
    check("R8 count saturate no reject", {31'd0, r}, 32'd0);
    xlate(1'b1, 2'd0, 16'h0078, 32'h0, 32'h0, 2'b01, "R8 R9 entry15 valid zero limit");
    xlate(1'b1, 2'd0, 16'h0080, 32'h0, 32'h0, 2'b11, "R8 index16 beyond depth");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_legacy();
        t_load();
        t_protected();
        t_index();
        t_reject();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule